// File: doc/BRIEF.md
# Keyed Boot and Programming Control Register

This block is one slice of a special-register file on a byte-wide register bus. It holds a control register that sets three things: programming permission for the on-chip code store, which code bank is used for boot, and whether the on-chip auxiliary RAM is enabled. The register can be changed only after software has written a fixed two-byte key, 87h and then 59h, to a separate key register. Until then, writes to the control register are dropped. The block also reports which bank the device booted from. It can raise a single-cycle software reset request, which puts the rest of the chip back in its power-on state.

The key is tracked by a three-state machine:

- `KEY_LOCKED`: no key has been seen. Writing 87h moves to `KEY_HALF`. Any other value stays in `KEY_LOCKED`.
- `KEY_HALF`: the first byte is in. Writing 59h moves to `KEY_OPEN`. Writing 87h again stays in `KEY_HALF`. Any other value returns to `KEY_LOCKED`.
- `KEY_OPEN`: control writes are accepted. Writing 87h drops back to `KEY_HALF`. Writing 59h stays in `KEY_OPEN`. Any other value returns to `KEY_LOCKED`.

A software reset returns the machine to `KEY_LOCKED` from every state.

The boot bank is taken from a strap input on the first clock after the external reset is released. A software reset forces the reported boot bank back to the main application bank.

Top module: `bootctl_guard`

## Requirements
- R1: While `rst_n` is low, `ctrl_writable`, `prog_en`, `bank_sel`, `aux_ram_en`, `swrst_req` and `loader_booted` are all 0, and the control register reads back as 00h.
- R2: A write to `CTRL_ADDR` while the key machine is not in `KEY_OPEN` leaves `prog_en`, `bank_sel`, `aux_ram_en` and the read-back value unchanged.
- R3: Writing 87h and then 59h to `KEY_ADDR` raises `ctrl_writable` in the cycle after the second write.
- R4: After 87h alone, `ctrl_writable` stays 0. A second byte other than 59h or 87h returns the machine to `KEY_LOCKED`. A repeated 87h keeps `KEY_HALF`, so the sequence 87h, 87h, 59h unlocks.
- R5: In `KEY_OPEN`, writing 87h or any value other than 59h to `KEY_ADDR` clears `ctrl_writable` in the next cycle. Writing 59h keeps it at 1.
- R6: An accepted control write copies write-data bit 0 to `prog_en`, bit 1 to `bank_sel` and bit 4 to `aux_ram_en`. Bits 2, 3, 5 and 6 are not stored.
- R7: The control register reads back with `prog_en` in bit 0, `bank_sel` in bit 1, `aux_ram_en` in bit 4, and bit 7 set when `loader_booted` or `swrst_req` is 1. All other bits read 0.
- R8: An accepted control write with bits 0, 1 and 7 all set raises `swrst_req` in the next cycle for exactly one cycle. That write does not change the stored control bits.
- R9: In the cycle after the `swrst_req` pulse, the block is in `KEY_LOCKED`, and `prog_en`, `bank_sel`, `aux_ram_en` and `loader_booted` are all 0.
- R10: An accepted control write with bit 7 set but bit 0 or bit 1 clear stores bits 0, 1 and 4 normally and raises no `swrst_req`.
- R11: `loader_booted` takes the value of `strap_loader` on the first clock edge after `rst_n` rises.
- R12: Reads at `KEY_ADDR`, or at any address other than `CTRL_ADDR`, return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low external reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register address for both reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| strap_loader | input | 1 | Boot-bank strap, sampled after reset release (1 = loader bank) |
| ctrl_writable | output | 1 | High while the key machine is in `KEY_OPEN` |
| prog_en | output | 1 | Code-store programming enable |
| bank_sel | output | 1 | Boot/program bank select |
| aux_ram_en | output | 1 | Auxiliary RAM enable |
| swrst_req | output | 1 | One-cycle software reset request |
| loader_booted | output | 1 | Device is currently booted from the loader bank |

## Verification
The hardest case to reach is the software reset. It needs a full unlock, then a trigger write, then a check in the single cycle where the pulse is high and bit 7 reads back as 1, then a check of the all-clear state in the next cycle.

The stimulus first stores a known nonzero value in the control register. This shows that the trigger write itself stores nothing. It also starts from a loader-strapped reset, so that clearing `loader_booted` is visible.

The key paths are driven as explicit byte sequences: 87h followed by a wrong byte, a repeated 87h, and key writes made while unlocked. After each sequence a control write is attempted and the read-back is compared, which shows whether the write was gated.

// File: rtl/bootctl_pkg.sv
package bootctl_pkg;

    localparam int REG_W = 8;

    // Control-register bit positions (software-visible layout)
    localparam int BIT_PROG   = 0;
    localparam int BIT_BANK   = 1;
    localparam int BIT_AUXRAM = 4;
    localparam int BIT_SWRST  = 7;

    typedef enum logic [1:0] {
        KEY_LOCKED = 2'd0,
        KEY_HALF   = 2'd1,
        KEY_OPEN   = 2'd2
    } key_state_e;

endpackage

// File: rtl/bootctl_unlock_fsm.sv
module bootctl_unlock_fsm
    import bootctl_pkg::*;
#(
    parameter logic [REG_W-1:0] KEY_FIRST  = 8'h87,
    parameter logic [REG_W-1:0] KEY_SECOND = 8'h59
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             key_wr,
    input  logic [REG_W-1:0] key_data,
    output logic             writable
);

    key_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KEY_LOCKED;
        end else if (clr) begin
            state_q <= KEY_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (key_wr) begin
            unique case (state_q)
                KEY_LOCKED: state_d = (key_data == KEY_FIRST) ? KEY_HALF : KEY_LOCKED;
                KEY_HALF: begin
                    if (key_data == KEY_SECOND)     state_d = KEY_OPEN;
                    else if (key_data == KEY_FIRST) state_d = KEY_HALF;
                    else                            state_d = KEY_LOCKED;
                end
                KEY_OPEN: begin
                    if (key_data == KEY_SECOND)     state_d = KEY_OPEN;
                    else if (key_data == KEY_FIRST) state_d = KEY_HALF;
                    else                            state_d = KEY_LOCKED;
                end
                default: state_d = KEY_LOCKED;
            endcase
        end
    end

    // Output logic
    always_comb begin
        writable = (state_q == KEY_OPEN);
    end

endmodule

// File: rtl/bootctl_ctrl_reg.sv
module bootctl_ctrl_reg
    import bootctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ok,
    input  logic [REG_W-1:0] wdata,
    input  logic             strap_loader,
    output logic             prog_en,
    output logic             bank_sel,
    output logic             aux_ram_en,
    output logic             swrst_req,
    output logic             loader_booted
);

    logic boot_sample_q;
    logic trigger;
    logic unused_wdata_bits;

    assign trigger = wr_ok && wdata[BIT_PROG] && wdata[BIT_BANK] && wdata[BIT_SWRST];
    assign unused_wdata_bits = ^{wdata[6:5], wdata[3:2]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_en       <= 1'b0;
            bank_sel      <= 1'b0;
            aux_ram_en    <= 1'b0;
            swrst_req     <= 1'b0;
            loader_booted <= 1'b0;
            boot_sample_q <= 1'b1;
        end else begin
            boot_sample_q <= 1'b0;
            if (boot_sample_q) begin
                loader_booted <= strap_loader;
            end
            if (swrst_req) begin
                prog_en       <= 1'b0;
                bank_sel      <= 1'b0;
                aux_ram_en    <= 1'b0;
                swrst_req     <= 1'b0;
                loader_booted <= 1'b0;
            end else if (trigger) begin
                swrst_req <= 1'b1;
            end else if (wr_ok) begin
                prog_en    <= wdata[BIT_PROG];
                bank_sel   <= wdata[BIT_BANK];
                aux_ram_en <= wdata[BIT_AUXRAM];
            end
        end
    end

endmodule

// File: rtl/bootctl_guard.sv
module bootctl_guard
    import bootctl_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hF6,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'hBF,
    parameter logic [REG_W-1:0]  KEY_FIRST  = 8'h87,
    parameter logic [REG_W-1:0]  KEY_SECOND = 8'h59
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              strap_loader,
    output logic              ctrl_writable,
    output logic              prog_en,
    output logic              bank_sel,
    output logic              aux_ram_en,
    output logic              swrst_req,
    output logic              loader_booted
);

    logic key_wr;
    logic ctrl_wr_ok;

    assign key_wr     = bus_wr && (bus_addr == KEY_ADDR);
    assign ctrl_wr_ok = bus_wr && (bus_addr == CTRL_ADDR) && ctrl_writable;

    bootctl_unlock_fsm #(
        .KEY_FIRST  (KEY_FIRST),
        .KEY_SECOND (KEY_SECOND)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (swrst_req),
        .key_wr   (key_wr),
        .key_data (bus_wdata),
        .writable (ctrl_writable)
    );

    bootctl_ctrl_reg reg_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_ok         (ctrl_wr_ok),
        .wdata         (bus_wdata),
        .strap_loader  (strap_loader),
        .prog_en       (prog_en),
        .bank_sel      (bank_sel),
        .aux_ram_en    (aux_ram_en),
        .swrst_req     (swrst_req),
        .loader_booted (loader_booted)
    );

    // Read-back mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_ADDR) begin
            bus_rdata[BIT_PROG]   = prog_en;
            bus_rdata[BIT_BANK]   = bank_sel;
            bus_rdata[BIT_AUXRAM] = aux_ram_en;
            bus_rdata[BIT_SWRST]  = loader_booted || swrst_req;
        end
    end

endmodule

// File: rtl/bootctl_guard_chk.sv
module bootctl_guard_chk
    import bootctl_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hF6,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'hBF,
    parameter logic [REG_W-1:0]  KEY_FIRST  = 8'h87,
    parameter logic [REG_W-1:0]  KEY_SECOND = 8'h59
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic              ctrl_writable,
    input logic              prog_en,
    input logic              bank_sel,
    input logic              aux_ram_en,
    input logic              swrst_req,
    input logic              loader_booted
);

    AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_writable && !swrst_req) |=> $stable({prog_en, bank_sel, aux_ram_en})); // R2

    AST_UNLOCK_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_writable) |-> $past(bus_wr && bus_addr == KEY_ADDR && bus_wdata == KEY_SECOND)); // R3

    AST_FIRST_KEY_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == KEY_ADDR && bus_wdata == KEY_FIRST) |=> !ctrl_writable); // R4

    AST_BAD_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == KEY_ADDR && bus_wdata != KEY_FIRST && bus_wdata != KEY_SECOND)
        |=> !ctrl_writable); // R5

    AST_TRIGGER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CTRL_ADDR && ctrl_writable && !swrst_req &&
         bus_wdata[BIT_PROG] && bus_wdata[BIT_BANK] && bus_wdata[BIT_SWRST]) |=> swrst_req); // R8

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_req |=> !swrst_req); // R8

    AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_req |=> (!ctrl_writable && !prog_en && !bank_sel && !aux_ram_en && !loader_booted)); // R9

endmodule

bind bootctl_guard bootctl_guard_chk #(
    .ADDR_W     (ADDR_W),
    .KEY_ADDR   (KEY_ADDR),
    .CTRL_ADDR  (CTRL_ADDR),
    .KEY_FIRST  (KEY_FIRST),
    .KEY_SECOND (KEY_SECOND)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .ctrl_writable (ctrl_writable),
    .prog_en       (prog_en),
    .bank_sel      (bank_sel),
    .aux_ram_en    (aux_ram_en),
    .swrst_req     (swrst_req),
    .loader_booted (loader_booted)
);

// File: tb/bootctl_guard_tb_top.sv
`timescale 1ns/1ps
module bootctl_guard_tb_top;

    localparam logic [7:0] KADDR = 8'hF6;
    localparam logic [7:0] CADDR = 8'hBF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       strap_loader = 1'b1;
    logic       ctrl_writable, prog_en, bank_sel, aux_ram_en, swrst_req, loader_booted;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    string      tag_q[$];
    logic [13:0] exp_q[$];

    always #5 clk = ~clk;

    bootctl_guard dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .strap_loader  (strap_loader),
        .ctrl_writable (ctrl_writable),
        .prog_en       (prog_en),
        .bank_sel      (bank_sel),
        .aux_ram_en    (aux_ram_en),
        .swrst_req     (swrst_req),
        .loader_booted (loader_booted)
    );

    // Driver: one register write, one cycle
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    // Driver: queue an expectation {rdata, writable, prog, bank, aux, swrst, loader}
    task automatic expect_at(input string tag, input logic [7:0] a, input logic [7:0] rd,
                             input logic w, input logic p, input logic b, input logic x,
                             input logic s, input logic l);
        bus_wr   = 1'b0;
        bus_addr = a;
        tag_q.push_back(tag);
        exp_q.push_back({rd, w, p, b, x, s, l});
        @(negedge clk);
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() > 0) begin
                logic [13:0] got, want;
                string t;
                want = exp_q.pop_front();
                t    = tag_q.pop_front();
                got  = {bus_rdata, ctrl_writable, prog_en, bank_sel, aux_ram_en, swrst_req, loader_booted};
                checks++;
                if (got !== want) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", t, got, want);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_at("R1 reset", CADDR, 8'h00, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_at("R11 strap", CADDR, 8'h80, 0, 0, 0, 0, 0, 1);

        wr(CADDR, 8'h13);
        expect_at("R2 locked write", CADDR, 8'h80, 0, 0, 0, 0, 0, 1);

        wr(KADDR, 8'h87);
        expect_at("R4 half closed", CADDR, 8'h80, 0, 0, 0, 0, 0, 1);
        wr(KADDR, 8'h59);
        expect_at("R3 unlocked", CADDR, 8'h80, 1, 0, 0, 0, 0, 1);

        wr(CADDR, 8'h7F);
        expect_at("R6 store bits", CADDR, 8'h93, 1, 1, 1, 1, 0, 1);
        wr(CADDR, 8'h91);
        expect_at("R10 bit7 only", CADDR, 8'h91, 1, 1, 0, 1, 0, 1);
        expect_at("R12 key read", KADDR, 8'h00, 1, 1, 0, 1, 0, 1);
        expect_at("R12 other read", 8'h00, 8'h00, 1, 1, 0, 1, 0, 1);

        wr(KADDR, 8'h00);
        expect_at("R5 bad key locks", CADDR, 8'h91, 0, 1, 0, 1, 0, 1);
        wr(CADDR, 8'h00);
        expect_at("R2 ignored after lock", CADDR, 8'h91, 0, 1, 0, 1, 0, 1);

        wr(KADDR, 8'h87);
        wr(KADDR, 8'h42);
        expect_at("R4 wrong second", CADDR, 8'h91, 0, 1, 0, 1, 0, 1);
        wr(KADDR, 8'h59);
        expect_at("R4 lone second stays locked", CADDR, 8'h91, 0, 1, 0, 1, 0, 1);
        wr(KADDR, 8'h87);
        wr(KADDR, 8'h87);
        wr(KADDR, 8'h59);
        expect_at("R4 repeated first unlocks", CADDR, 8'h91, 1, 1, 0, 1, 0, 1);

        wr(KADDR, 8'h59);
        expect_at("R5 second keeps open", CADDR, 8'h91, 1, 1, 0, 1, 0, 1);
        wr(KADDR, 8'h87);
        expect_at("R5 first closes", CADDR, 8'h91, 0, 1, 0, 1, 0, 1);
        wr(KADDR, 8'h59);
        expect_at("R3 reopen", CADDR, 8'h91, 1, 1, 0, 1, 0, 1);

        wr(CADDR, 8'h02);
        expect_at("R7 readback layout", CADDR, 8'h82, 1, 0, 1, 0, 0, 1);

        wr(CADDR, 8'h83);
        expect_at("R8 pulse", CADDR, 8'h82, 1, 0, 1, 0, 1, 1);
        expect_at("R9 cleared", CADDR, 8'h00, 0, 0, 0, 0, 0, 0);
        expect_at("R8 single cycle", CADDR, 8'h00, 0, 0, 0, 0, 0, 0);
        wr(CADDR, 8'h13);
        expect_at("R9 locked after swrst", CADDR, 8'h00, 0, 0, 0, 0, 0, 0);

        wr(KADDR, 8'h87);
        wr(KADDR, 8'h59);
        wr(CADDR, 8'hFF);
        expect_at("R8 pulse full byte", CADDR, 8'h80, 1, 0, 0, 0, 1, 0);
        expect_at("R9 cleared again", CADDR, 8'h00, 0, 0, 0, 0, 0, 0);

        strap_loader = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_at("R11 strap main", CADDR, 8'h00, 0, 0, 0, 0, 0, 0);

        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule